// File: doc/BRIEF.md
# Segmentable Tapped Shift Register

A 64-stage serial shift register with four tap points, one at the end of each 16-stage quarter. A single mode input selects between two arrangements. With the mode LOW the quarters are linked end to end into one long chain, and all four taps drive the contents of their stages. With the mode HIGH the tap drivers are released, and the first three taps act as serial inputs. Each of them feeds the quarter that follows it, so the register becomes four independent 16-stage chains.

Each tap is modelled as a separate data value and output-enable. The three taps that can be inputs also have an input value. The last tap is never an input, so it has no input port. A pad wrapper may merge these into real bidirectional pins. There is no reset. Contents are defined once enough bits have been shifted in, and they are held indefinitely while the clock is stopped. A two-channel arrangement is made by instantiating the block twice.

Top module: `tapped_shift_register`

## Requirements
- R1: On every rising clock edge, `ser_in` is loaded into stage 1, at either level of `seg_mode`.
- R2: While `seg_mode` is 0, every bit of `tap_oe` is 1, and `tap_out[k]` shows stage 16(k+1) (bit 0 is stage 16, bit 3 is stage 64).
- R3: While `seg_mode` is 0 at an edge, every stage moves one position onward, and stage 17, 33 and 49 take the old content of stage 16, 32 and 48. A bit therefore reaches `tap_out[3]` 64 edges after it enters.
- R4: While `seg_mode` is 1, every bit of `tap_oe` is 0.
- R5: While `seg_mode` is 1 at an edge, `tap_in[0]`, `tap_in[1]` and `tap_in[2]` are loaded into stage 17, 33 and 49. Each 16-stage quarter shifts on its own, so a bit on `tap_in[k]` reaches `tap_out[k+1]` 16 edges later.
- R6: Stage 64 takes input only from stage 63. No port can load the last quarter other than `tap_in[2]` by way of stage 49.
- R7: Without a rising clock edge no stage changes, whatever the data and tap inputs do.
- R8: `tap_oe` follows `seg_mode` combinationally, with no clock edge needed.
- R9: While `seg_mode` is 0, the values on `tap_in` have no effect on any stage.
- R10: `seg_mode` is sampled at the same edge as the data. A change of mode decides how the chain links from the next rising edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| ser_in | input | 1 | Serial data into stage 1 |
| seg_mode | input | 1 | 0: one 64-stage chain, taps driven; 1: four 16-stage chains, taps released |
| tap_in | input | NUM_SEG-1 | Values seen at taps 0..2, used as quarter inputs in segmented mode |
| tap_out | output | NUM_SEG | Contents of stages 16, 32, 48, 64 |
| tap_oe | output | NUM_SEG | Output enable of each tap driver |

## Verification
The bench builds the block with its default parameters: 16 stages per segment and 4 segments. With these values a full 64-stage traversal takes only a few dozen cycles, so the complete chain can be filled from a known pattern, run through thousands of random cycles with mode changes, and checked tap by tap against a bit-level model. Sixteen-edge windows in segmented mode reach every boundary where a tap input enters a quarter. Stopping the clock shows that the register holds its contents while the enables follow the mode with no clock running.

// File: rtl/tsr_pkg.sv
package tsr_pkg;

  // Source of the first stage of a non-leading segment.
  function automatic logic link_pick(input logic seg_mode,
                                     input logic chain_bit,
                                     input logic ext_bit);
    return seg_mode ? ext_bit : chain_bit;
  endfunction

  // Tap driver enable for a given mode level.
  function automatic logic tap_enable(input logic seg_mode);
    return ~seg_mode;
  endfunction

  // Stage number (1-based) that tap k displays.
  function automatic int tap_stage(input int k, input int seg_len);
    return (k + 1) * seg_len;
  endfunction

endpackage

// File: rtl/tsr_segment.sv
module tsr_segment #(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic din,
  output logic head_q,
  output logic tail_q
);
  logic [LEN-1:0] stg;

  always_ff @(posedge clk) begin
    stg <= {stg[LEN-2:0], din};
  end

  assign head_q = stg[0];
  assign tail_q = stg[LEN-1];
endmodule

// File: rtl/tsr_link.sv
module tsr_link
  import tsr_pkg::*;
(
  input  logic seg_mode,
  input  logic chain_bit,
  input  logic ext_bit,
  output logic link_bit
);
  assign link_bit = link_pick(seg_mode, chain_bit, ext_bit);
endmodule

// File: rtl/tsr_tap_drv.sv
module tsr_tap_drv
  import tsr_pkg::*;
#(
  parameter int NUM_SEG = 4
) (
  input  logic               seg_mode,
  input  logic [NUM_SEG-1:0] tail,
  output logic [NUM_SEG-1:0] tap_out,
  output logic [NUM_SEG-1:0] tap_oe
);
  for (genvar k = 0; k < NUM_SEG; k++) begin : g_tap
    assign tap_oe[k]  = tap_enable(seg_mode);
    assign tap_out[k] = tail[k];
  end
endmodule

// File: rtl/tapped_shift_register.sv
module tapped_shift_register #(
  parameter int SEG_LEN = 16,
  parameter int NUM_SEG = 4
) (
  input  logic               clk,
  input  logic               ser_in,
  input  logic               seg_mode,
  input  logic [NUM_SEG-2:0] tap_in,
  output logic [NUM_SEG-1:0] tap_out,
  output logic [NUM_SEG-1:0] tap_oe
);
  localparam int TOTAL = SEG_LEN * NUM_SEG;

  // Named internal events for the checker.
  logic [NUM_SEG-1:0] seg_head;   // bit entering each segment
  logic [NUM_SEG-1:0] seg_first;  // first stage of each segment
  logic [NUM_SEG-1:0] seg_tail;   // last stage of each segment

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_seg
    tsr_segment #(.LEN(SEG_LEN)) u_seg (
      .clk    (clk),
      .din    (seg_head[g]),
      .head_q (seg_first[g]),
      .tail_q (seg_tail[g])
    );
    if (g == 0) begin : g_lead
      assign seg_head[g] = ser_in;
    end else begin : g_join
      tsr_link u_link (
        .seg_mode  (seg_mode),
        .chain_bit (seg_tail[g-1]),
        .ext_bit   (tap_in[g-1]),
        .link_bit  (seg_head[g])
      );
    end
  end

  tsr_tap_drv #(.NUM_SEG(NUM_SEG)) u_drv (
    .seg_mode (seg_mode),
    .tail     (seg_tail),
    .tap_out  (tap_out),
    .tap_oe   (tap_oe)
  );

  initial begin
    if (SEG_LEN < 2 || NUM_SEG < 2 || TOTAL < 4)
      $display("tapped_shift_register: SEG_LEN and NUM_SEG must be at least 2");
  end
endmodule

// File: rtl/tsr_checker.sv
module tsr_checker #(
  parameter int SEG_LEN = 16,
  parameter int NUM_SEG = 4
) (
  input logic               clk,
  input logic               ser_in,
  input logic               seg_mode,
  input logic [NUM_SEG-2:0] tap_in,
  input logic [NUM_SEG-1:0] tap_out,
  input logic [NUM_SEG-1:0] tap_oe,
  input logic [NUM_SEG-1:0] seg_first
);
  bit primed;
  always_ff @(posedge clk) primed <= 1'b1;

  // R1: serial input lands in stage 1 at every edge.
  a_r1_ser_load: assert property (@(posedge clk) disable iff (!primed)
    1'b1 |=> seg_first[0] == $past(ser_in));

  // R2 / R8: drivers on in chain mode.
  a_r2_oe_on: assert property (@(posedge clk) disable iff (!primed)
    !seg_mode |-> tap_oe == {NUM_SEG{1'b1}});

  // R4 / R8: drivers released in segmented mode.
  a_r4_oe_off: assert property (@(posedge clk) disable iff (!primed)
    seg_mode |-> tap_oe == {NUM_SEG{1'b0}});

  for (genvar k = 1; k < NUM_SEG; k++) begin : g_join
    // R5 / R10: tap input loads the first stage of the next segment.
    a_r5_ext_load: assert property (@(posedge clk) disable iff (!primed)
      seg_mode |=> seg_first[k] == $past(tap_in[k-1]));
    // R3 / R9: chain mode links from the previous tap, ignoring tap_in.
    a_r9_chain_link: assert property (@(posedge clk) disable iff (!primed)
      !seg_mode |=> seg_first[k] == $past(tap_out[k-1]));
  end
endmodule

bind tapped_shift_register tsr_checker #(
  .SEG_LEN (SEG_LEN),
  .NUM_SEG (NUM_SEG)
) u_chk (
  .clk       (clk),
  .ser_in    (ser_in),
  .seg_mode  (seg_mode),
  .tap_in    (tap_in),
  .tap_out   (tap_out),
  .tap_oe    (tap_oe),
  .seg_first (seg_first)
);

// File: tb/test_tapped_shift_register.sv
`timescale 1ns/1ps
module test_tapped_shift_register;
  localparam int SL  = 16;
  localparam int NS  = 4;
  localparam int TOT = SL * NS;

  logic clk = 1'b0;
  logic clk_run = 1'b0;
  logic ser_in = 1'b0;
  logic seg_mode = 1'b0;
  logic [NS-2:0] tap_in = '0;
  logic [NS-1:0] tap_out, tap_oe;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  logic [TOT-1:0] mdl = '0;   // mdl[i] is stage i+1

  tapped_shift_register #(.SEG_LEN(SL), .NUM_SEG(NS)) i_tapped_shift_register (
    .clk(clk), .ser_in(ser_in), .seg_mode(seg_mode),
    .tap_in(tap_in), .tap_out(tap_out), .tap_oe(tap_oe)
  );

  always #2.5 clk = clk_run ? ~clk : 1'b0;

  function automatic logic [TOT-1:0] bench_step(input logic [TOT-1:0] m,
      input logic s, input logic mode, input logic [NS-2:0] ti);
    logic [TOT-1:0] n;
    n[0] = s;
    for (int i = 1; i < TOT; i++) begin
      if (mode && (i % SL == 0)) n[i] = ti[i/SL - 1];
      else n[i] = m[i-1];
    end
    return n;
  endfunction

  function automatic logic [NS-1:0] exp_taps(input logic [TOT-1:0] m);
    logic [NS-1:0] t;
    for (int k = 0; k < NS; k++) t[k] = m[SL*k + SL - 1];
    return t;
  endfunction

  always @(posedge clk) mdl = bench_step(mdl, ser_in, seg_mode, tap_in);

  task automatic expect_bits(input string req, input logic [NS-1:0] act,
                             input logic [NS-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_now(input string req);
    expect_bits(req, tap_oe, seg_mode ? {NS{1'b0}} : {NS{1'b1}});
    expect_bits(req, tap_out, exp_taps(mdl));
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #(150000 * 5);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=running expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    logic [NS-1:0] held;
    void'($urandom(32'd4517));
    clk_run = 1'b1;

    // R3: fill the whole chain with a known pattern in chain mode.
    @(negedge clk);
    for (int i = 0; i < TOT; i++) begin
      ser_in = (i % 3 == 0);
      @(negedge clk);
    end
    check_now("R3");
    check_now("R2");

    // R1: segmented mode still loads ser_in; ones reach tap 0 after 16 edges.
    seg_mode = 1'b1; tap_in = '0; ser_in = 1'b1;
    repeat (SL) @(negedge clk);
    expect_bits("R1", {3'b000, tap_out[0]}, 4'b0001);
    check_now("R5");

    // R5 / R6 / R4: tap inputs feed the following quarters.
    ser_in = 1'b0; tap_in = 3'b101;
    repeat (SL) @(negedge clk);
    expect_bits("R5", tap_out, 4'b1010);
    expect_bits("R6", {tap_out[3], 3'b000}, 4'b1000);
    expect_bits("R4", tap_oe, 4'b0000);

    // R9: chain mode ignores tap_in entirely.
    seg_mode = 1'b0; ser_in = 1'b0;
    for (int i = 0; i < TOT; i++) begin
      tap_in = 3'($urandom);
      @(negedge clk);
    end
    expect_bits("R9", tap_out, 4'b0000);
    check_now("R9");

    // R10: mode change applies from the next edge.
    tap_in = 3'b111; seg_mode = 1'b1;
    @(negedge clk);
    seg_mode = 1'b0; tap_in = 3'b000;
    repeat (SL - 1) @(negedge clk);
    expect_bits("R10", tap_out, 4'b1110);
    check_now("R10");

    // R7 / R8: stop the clock, disturb inputs, nothing moves; enables follow mode.
    clk_run = 1'b0;
    #3;
    held = tap_out;
    ser_in = 1'b1; tap_in = 3'b010;
    #20;
    expect_bits("R7", tap_out, held);
    seg_mode = 1'b1; #1;
    expect_bits("R8", tap_oe, 4'b0000);
    tap_in = 3'b101; #5;
    expect_bits("R7", tap_out, held);
    seg_mode = 1'b0; #1;
    expect_bits("R8", tap_oe, 4'b1111);
    expect_bits("R7", tap_out, exp_taps(mdl));
    clk_run = 1'b1;

    // Random traffic with occasional mode changes.
    @(negedge clk);
    for (int c = 0; c < 3000; c++) begin
      check_now(seg_mode ? "R5" : "R3");
      ser_in = 1'($urandom);
      tap_in = 3'($urandom);
      if ($urandom % 8 == 0) seg_mode = ~seg_mode;
      @(negedge clk);
    end

    done = 1;
    report();
    $finish;
  end
endmodule